// File: doc/BRIEF.md
# Operand Address Generator

This block sits between instruction decode and the data memory port of a 16-bit CPU whose memory is addressed in whole 16-bit words. Each cycle that decode presents a request, the block takes a 3-bit operand mode, a base register value, an index register value, the current stack pointer and the instruction word that follows the opcode. From these it produces one of two things. The first is a direct operand value. The second is a memory word address together with an access request. When the mode changes a register, it also produces the value to write back into the register file.

Stack operations bypass the mode field. A push writes through the stack pointer after moving it down one word. A pop reads at the stack pointer and then moves it up one word. The stack therefore grows downward, and the stack pointer always holds the address of the last word pushed.

All outputs are registered. They appear one clock after the request and hold for one cycle only.

Top module: `operand_agu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: Mode 0 (immediate) gives `opnd_vld`=1 and `opnd`=`next_word`. It raises `ext_used`, issues no memory request and no write-back.
- R3: Mode 1 (absolute) requests a memory read at `mem_addr`=`next_word` and raises `ext_used`. It does not present an operand and does not write back.
- R4: Mode 2 (register) gives `opnd`=`base_val` with `opnd_vld`=1. Mode 3 (indirect) requests a read at `base_val`. Neither mode raises `ext_used` or writes back.
- R5: Mode 4 (indexed) requests a read at (`base_val`+`index_val`) mod 2^16.
- R6: Mode 5 (post-increment) reads at `base_val`. It writes back `base_val`+1 mod 2^16 to the base register, with `wb_en`=1 and `wb_sp`=0.
- R7: Mode 6 (pre-decrement) reads at `base_val`-1 mod 2^16. It writes the same value back to the base register.
- R8: `push`=1 issues a write (`mem_wr`=1) at `sp_val`-1 mod 2^16 and writes that value back to the stack pointer (`wb_sp`=1). `pop`=1 issues a read at `sp_val` and writes back `sp_val`+1 mod 2^16 to the stack pointer. Both ignore `mode`, and neither raises `ext_used`.
- R9: Mode 7 with no stack operation, or `push` and `pop` both set, raises `illegal`. No request, operand or write-back is issued.
- R10: Every result appears exactly one cycle after the request and sets `out_valid`. A cycle with `in_valid`=0 yields all outputs zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Operand mode, encodings as in R2 to R9 |
| push | input | 1 | Stack push request |
| pop | input | 1 | Stack pop request |
| base_val | input | 16 | Base register value |
| index_val | input | 16 | Index register value |
| sp_val | input | 16 | Stack pointer value |
| next_word | input | 16 | Instruction word after the opcode |
| out_valid | output | 1 | Result present |
| illegal | output | 1 | Reserved mode or conflicting stack request |
| ext_used | output | 1 | Extra instruction word consumed |
| opnd_vld | output | 1 | `opnd` carries the operand |
| opnd | output | 16 | Direct operand value |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory word address |
| wb_en | output | 1 | Register write-back enable |
| wb_sp | output | 1 | Write-back target: 1 stack pointer, 0 base register |
| wb_data | output | 16 | Write-back value |

## Verification
A decode fault in this block appears as the wrong strobe, or a missing one, in the cycle after the request. Examples are a request issued alongside an operand, a write-back in a mode that should leave registers alone, or the wrong write-back target. An adder or step fault appears as an address or write-back value that is off by one word, or that fails to wrap at the ends of the 16-bit range. Both kinds show at the ports in that same single cycle. Sweeping every mode and every stack combination against values at the wrap boundaries exposes each fault on the first affected request.

// File: rtl/operand_agu.sv
module operand_agu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   mode,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] index_val,
  input  logic [W-1:0] sp_val,
  input  logic [W-1:0] next_word,
  output logic         out_valid,
  output logic         illegal,
  output logic         ext_used,
  output logic         opnd_vld,
  output logic [W-1:0] opnd,
  output logic         mem_req,
  output logic         mem_wr,
  output logic [W-1:0] mem_addr,
  output logic         wb_en,
  output logic         wb_sp,
  output logic [W-1:0] wb_data
);

  localparam logic [W-1:0] ONE = W'(1);

  logic         n_ill, n_ext, n_ov, n_req, n_wr, n_wen, n_wsp;
  logic [W-1:0] n_opnd, n_addr, n_wdata;
  logic [W-1:0] base_inc, base_dec, sp_inc, sp_dec, idx_sum;

  assign base_inc = base_val + ONE;
  assign base_dec = base_val - ONE;
  assign sp_inc   = sp_val + ONE;
  assign sp_dec   = sp_val - ONE;
  assign idx_sum  = base_val + index_val;

  always_comb begin
    n_ill = 1'b0; n_ext = 1'b0; n_ov = 1'b0; n_req = 1'b0;
    n_wr = 1'b0; n_wen = 1'b0; n_wsp = 1'b0;
    n_opnd = '0; n_addr = '0; n_wdata = '0;
    if (in_valid) begin
      if (push && pop) begin
        n_ill = 1'b1;
      end else if (push) begin
        n_req = 1'b1; n_wr = 1'b1; n_addr = sp_dec;
        n_wen = 1'b1; n_wsp = 1'b1; n_wdata = sp_dec;
      end else if (pop) begin
        n_req = 1'b1; n_addr = sp_val;
        n_wen = 1'b1; n_wsp = 1'b1; n_wdata = sp_inc;
      end else begin
        case (mode)
          3'd0: begin n_ov = 1'b1; n_opnd = next_word; n_ext = 1'b1; end
          3'd1: begin n_req = 1'b1; n_addr = next_word; n_ext = 1'b1; end
          3'd2: begin n_ov = 1'b1; n_opnd = base_val; end
          3'd3: begin n_req = 1'b1; n_addr = base_val; end
          3'd4: begin n_req = 1'b1; n_addr = idx_sum; end
          3'd5: begin
            n_req = 1'b1; n_addr = base_val;
            n_wen = 1'b1; n_wdata = base_inc;
          end
          3'd6: begin
            n_req = 1'b1; n_addr = base_dec;
            n_wen = 1'b1; n_wdata = base_dec;
          end
          default: n_ill = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; illegal <= 1'b0; ext_used <= 1'b0; opnd_vld <= 1'b0;
      opnd <= '0; mem_req <= 1'b0; mem_wr <= 1'b0; mem_addr <= '0;
      wb_en <= 1'b0; wb_sp <= 1'b0; wb_data <= '0;
    end else begin
      out_valid <= in_valid; illegal <= n_ill; ext_used <= n_ext; opnd_vld <= n_ov;
      opnd <= n_opnd; mem_req <= n_req; mem_wr <= n_wr; mem_addr <= n_addr;
      wb_en <= n_wen; wb_sp <= n_wsp; wb_data <= n_wdata;
    end
  end

  AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && opnd_vld) && !(illegal && (mem_req || opnd_vld || wb_en))) else $error("AST_ONE_RESULT_KIND"); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(mem_req || opnd_vld || wb_en || illegal || ext_used)) else $error("AST_QUIET_WHEN_IDLE"); // R10
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !wb_sp && !mem_wr && $past(in_valid && !push && !pop && mode == 3'd5)) |-> wb_data == mem_addr + ONE) else $error("AST_POSTINC_STEP"); // R6
  AST_PREDEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && $past(in_valid && !push && !pop && mode == 3'd6)) |-> (wb_data == mem_addr && !wb_sp)) else $error("AST_PREDEC_STEP"); // R7
  AST_PUSH_FULL_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr) |-> (wb_en && wb_sp && wb_data == mem_addr && mem_addr == $past(sp_val) - ONE)) else $error("AST_PUSH_FULL_DESC"); // R8
  AST_EXT_ONLY_FIRST_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_used |-> ($past(mode) <= 3'd1 && !wb_en)) else $error("AST_EXT_ONLY_FIRST_MODES"); // R2

endmodule

// File: tb/test_operand_agu.sv
module test_operand_agu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] mode = '0;
  logic push = 1'b0, pop = 1'b0;
  logic [15:0] base_val = '0, index_val = '0, sp_val = '0, next_word = '0;
  logic out_valid, illegal, ext_used, opnd_vld, mem_req, mem_wr, wb_en, wb_sp;
  logic [15:0] opnd, mem_addr, wb_data;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  operand_agu i_operand_agu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .push(push), .pop(pop),
    .base_val(base_val), .index_val(index_val), .sp_val(sp_val), .next_word(next_word),
    .out_valid(out_valid), .illegal(illegal), .ext_used(ext_used), .opnd_vld(opnd_vld),
    .opnd(opnd), .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .wb_en(wb_en), .wb_sp(wb_sp), .wb_data(wb_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'h3A5C;
    endcase
  endfunction

  task automatic all_zero(input string req);
    chk(req, "out_valid", out_valid, 0); chk(req, "illegal", illegal, 0);
    chk(req, "ext_used", ext_used, 0); chk(req, "opnd_vld", opnd_vld, 0);
    chk(req, "opnd", opnd, 0); chk(req, "mem_req", mem_req, 0);
    chk(req, "mem_wr", mem_wr, 0); chk(req, "mem_addr", mem_addr, 0);
    chk(req, "wb_en", wb_en, 0); chk(req, "wb_sp", wb_sp, 0);
    chk(req, "wb_data", wb_data, 0);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string rq;
    logic [15:0] b, x, s, n;
    logic e_ill, e_ext, e_ov, e_req, e_wr, e_wen, e_wsp;
    logic [15:0] e_opnd, e_addr, e_wdata;

    repeat (3) @(posedge clk);
    #1;
    all_zero("R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    all_zero("R1");

    for (int op = 0; op < 4; op++) begin
      for (int m = 0; m < 8; m++) begin
        for (int bi = 0; bi < 6; bi++) begin
          for (int xi = 0; xi < 6; xi++) begin
            b = pick(bi); x = pick(xi);
            s = pick((bi + xi) % 6); n = pick((xi + 3) % 6) ^ 16'h0F0F;
            in_valid = 1'b1; mode = 3'(m);
            push = op[0]; pop = op[1];
            base_val = b; index_val = x; sp_val = s; next_word = n;
            e_ill = 0; e_ext = 0; e_ov = 0; e_req = 0; e_wr = 0; e_wen = 0; e_wsp = 0;
            e_opnd = 0; e_addr = 0; e_wdata = 0;
            if (op == 3) begin rq = "R9"; e_ill = 1; end
            else if (op == 1) begin
              rq = "R8"; e_req = 1; e_wr = 1; e_addr = 16'((32'(s) + 32'hFFFF) % 32'h10000);
              e_wen = 1; e_wsp = 1; e_wdata = e_addr;
            end else if (op == 2) begin
              rq = "R8"; e_req = 1; e_addr = s; e_wen = 1; e_wsp = 1;
              e_wdata = 16'((32'(s) + 1) % 32'h10000);
            end else begin
              case (m)
                0: begin rq = "R2"; e_ov = 1; e_opnd = n; e_ext = 1; end
                1: begin rq = "R3"; e_req = 1; e_addr = n; e_ext = 1; end
                2: begin rq = "R4"; e_ov = 1; e_opnd = b; end
                3: begin rq = "R4"; e_req = 1; e_addr = b; end
                4: begin rq = "R5"; e_req = 1; e_addr = 16'((32'(b) + 32'(x)) % 32'h10000); end
                5: begin rq = "R6"; e_req = 1; e_addr = b; e_wen = 1;
                         e_wdata = 16'((32'(b) + 1) % 32'h10000); end
                6: begin rq = "R7"; e_req = 1; e_addr = 16'((32'(b) + 32'hFFFF) % 32'h10000);
                         e_wen = 1; e_wdata = e_addr; end
                default: begin rq = "R9"; e_ill = 1; end
              endcase
            end
            @(posedge clk); #1;
            chk("R10", "out_valid", out_valid, 1);
            chk(rq, "illegal", illegal, e_ill); chk(rq, "ext_used", ext_used, e_ext);
            chk(rq, "opnd_vld", opnd_vld, e_ov); chk(rq, "opnd", opnd, e_opnd);
            chk(rq, "mem_req", mem_req, e_req); chk(rq, "mem_wr", mem_wr, e_wr);
            chk(rq, "mem_addr", mem_addr, e_addr); chk(rq, "wb_en", wb_en, e_wen);
            chk(rq, "wb_sp", wb_sp, e_wsp); chk(rq, "wb_data", wb_data, e_wdata);
          end
        end
        in_valid = 1'b0;
        @(posedge clk); #1;
        all_zero("R10");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule